// File: doc/BRIEF.md
# Serial Digit Loader with Handshake

This block receives one display character per transaction over a three-wire serial link (a data line, a data clock and an active-low write strobe) and keeps a memory of ten seven-segment digits, each with two annunciator flags. Bits are taken on rising data-clock edges into a shift register. A bit counter follows the transfer. It drives an active-low "frame ready" handshake once a full character and address have arrived, and it throws a transfer away when too many clock edges come in.

The end of a write-strobe pulse (its rising edge) has two meanings. If the handshake is low, it decodes the received 4-bit character code into segments and stores the result, with the annunciator flags, in the addressed digit. If the handshake is high, it only clears the receiver. In both cases the receiver is empty afterwards. The annunciator bits travel first on the line, so a host that sends only the last eight bits writes the character with both flags off.

The data, data-clock and strobe inputs may be asynchronous. They are synchronised into the system clock before edges are detected.

Top module: `serial_digit_loader`

## Requirements
- R1: After reset, `ready_n` is 1 and every bit of `disp_seg` and `disp_ann` is 0.
- R2: `sdata` is sampled on each rising edge of `sclk`. The bit order on the line is AN1, AN2, BD0, BD1, BD2, BD3, A0, A1, A2, A3. BD3 is the MSB of the character code and A3 is the MSB of the digit address.
- R3: `ready_n` stays 1 while fewer than 8 bits are held. It goes to 0 once 8 bits are held, and stays 0 at 9 and 10 bits.
- R4: An 11th rising `sclk` edge in one transfer clears the receiver: `ready_n` returns to 1, and a following strobe changes no digit.
- R5: A rising edge of `wr_n` while `ready_n` is 0 stores the decoded character and flags in the addressed digit, then clears the receiver so that `ready_n` is 1.
- R6: A rising edge of `wr_n` while `ready_n` is 1 leaves the display unchanged and clears the receiver, so the next bits start a new transfer.
- R7: Bits that were not sent read as 0. An 8-bit transfer stores both flags off. In a 9-bit transfer the first bit is AN2. A 10-bit transfer sets both flags.
- R8: A strobe that commits an address of 10 to 15 changes no digit.
- R9: Digit d uses segment bits `disp_seg[7d+6:7d]`, ordered g,f,e,d,c,b,a from bit 6 down to bit 0. The code decode is:
  - 0..9: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F
  - 10 (dash): 40
  - 11 (E): 79
  - 12 (H): 76
  - 13 (L): 38
  - 14 (P): 73
  - 15: blank, 00
- R10: Digit d shows AN1 on `disp_ann[2d]` and AN2 on `disp_ann[2d+1]`. A commit changes only the addressed digit.
- R11: When a rising `wr_n` edge and a rising `sclk` edge are seen in the same cycle, the strobe acts and the clock edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data line |
| sclk | input | 1 | Serial data clock, sampled on rising edges |
| wr_n | input | 1 | Active-low write strobe, acts on its rising edge |
| ready_n | output | 1 | Low when at least 8 bits are held |
| disp_seg | output | 70 | Segment pattern for each digit, 7 bits per digit |
| disp_ann | output | 20 | Annunciator flags for each digit, 2 bits per digit |

## Verification
The bench builds the block with its defaults: ten digits, a 4-bit address and two synchroniser stages. The 4-bit address field brings the non-existent digit addresses 10 to 15 within reach, so R8 is exercised with real line traffic. Ten digits let all sixteen character codes be written across different digits while the untouched ones are checked to keep their contents. Two synchroniser stages keep each serial bit short enough for the aborted, shortened and colliding-edge transfers to run back to back.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int SEG_W  = 7;
  localparam int CODE_W = 4;
  localparam int ANN_W  = 2;

  typedef struct packed {
    logic             an2;
    logic             an1;
    logic [SEG_W-1:0] seg;
  } cell_t;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdl_rx_ctrl.sv
module sdl_rx_ctrl #(
  parameter int FRAME_W     = 10,
  parameter int ACCEPT_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               wr_n_s,
  input  logic               data_s,
  output logic               ready_n,
  output logic               commit,
  output logic [FRAME_W-1:0] frame
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_ACC  = CNT_W'(ACCEPT_BITS);

  logic               sclk_prev_q, wr_prev_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               clk_rise, wr_rise, enough;

  assign clk_rise = sclk_s & ~sclk_prev_q;
  assign wr_rise  = wr_n_s & ~wr_prev_q;
  assign enough   = (cnt_q >= CNT_ACC);

  // Next state: the strobe has priority over a data-clock edge.
  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (wr_rise) begin
      cnt_d = '0;
      sr_d  = '0;
    end else if (clk_rise) begin
      if (cnt_q == CNT_FULL) begin
        cnt_d = '0;
        sr_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sr_d  = {sr_q[FRAME_W-2:0], data_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      wr_prev_q   <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      wr_prev_q   <= wr_n_s;
      cnt_q       <= cnt_d;
      sr_q        <= sr_d;
    end
  end

  assign ready_n = ~enough;
  assign commit  = wr_rise & enough;
  assign frame   = sr_q;

  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !wr_rise && cnt_q == CNT_FULL) |=> (ready_n && sr_q == '0));
  a_r3_ready_at_eight: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !wr_rise && cnt_q == CNT_ACC - 1'b1) |=> !ready_n);
  a_r5_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> (ready_n && cnt_q == '0));
  a_r11_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && clk_rise) |=> (sr_q == '0));
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !wr_rise && cnt_q < CNT_FULL) |=> (sr_q[0] == $past(data_s)));
endmodule

// File: rtl/sdl_codeb.sv
module sdl_codeb
  import sdl_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  seg
);
  always_comb begin
    unique case (code)
      4'd0:  seg = 7'h3F;
      4'd1:  seg = 7'h06;
      4'd2:  seg = 7'h5B;
      4'd3:  seg = 7'h4F;
      4'd4:  seg = 7'h66;
      4'd5:  seg = 7'h6D;
      4'd6:  seg = 7'h7D;
      4'd7:  seg = 7'h07;
      4'd8:  seg = 7'h7F;
      4'd9:  seg = 7'h6F;
      4'd10: seg = 7'h40;
      4'd11: seg = 7'h79;
      4'd12: seg = 7'h76;
      4'd13: seg = 7'h38;
      4'd14: seg = 7'h73;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/sdl_digit_store.sv
module sdl_digit_store
  import sdl_pkg::*;
#(
  parameter int NUM_DIGITS = 10,
  parameter int ADDR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [ANN_W+CODE_W+ADDR_W-1:0] frame,
  output logic [NUM_DIGITS*SEG_W-1:0] disp_seg,
  output logic [NUM_DIGITS*ANN_W-1:0] disp_ann
);
  localparam int FRAME_W = ANN_W + CODE_W + ADDR_W;

  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] addr;
  logic              an1, an2;
  logic [SEG_W-1:0]  seg_new;
  cell_t             cell_new;
  cell_t [NUM_DIGITS-1:0] cells_q;

  // Field extraction: first-sent bit sits at the top of the frame.
  always_comb begin
    an1 = frame[FRAME_W-1];
    an2 = frame[FRAME_W-2];
    for (int i = 0; i < CODE_W; i++) code[i] = frame[FRAME_W-3-i];
    for (int i = 0; i < ADDR_W; i++) addr[i] = frame[ADDR_W-1-i];
  end

  sdl_codeb u_dec (.code(code), .seg(seg_new));

  assign cell_new = '{an2: an2, an1: an1, seg: seg_new};

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic we;
    assign we = commit && (addr == ADDR_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cells_q[d] <= '0;
      else if (we) cells_q[d] <= cell_new;
    end
    assign disp_seg[d*SEG_W +: SEG_W] = cells_q[d].seg;
    assign disp_ann[d*ANN_W]          = cells_q[d].an1;
    assign disp_ann[d*ANN_W + 1]      = cells_q[d].an2;
  end

  a_r8_bad_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && int'(addr) >= NUM_DIGITS) |=> $stable(cells_q));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cells_q));
endmodule

// File: rtl/serial_digit_loader.sv
module serial_digit_loader
  import sdl_pkg::*;
#(
  parameter int NUM_DIGITS  = 10,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sdata,
  input  logic                        sclk,
  input  logic                        wr_n,
  output logic                        ready_n,
  output logic [NUM_DIGITS*SEG_W-1:0] disp_seg,
  output logic [NUM_DIGITS*ANN_W-1:0] disp_ann
);
  localparam int FRAME_W     = ANN_W + CODE_W + ADDR_W;
  localparam int ACCEPT_BITS = CODE_W + ADDR_W;

  logic [2:0]         pins_s;
  logic               commit;
  logic [FRAME_W-1:0] frame;

  // Bit 2: strobe (idle high), bit 1: data clock, bit 0: data.
  sdl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({wr_n, sclk, sdata}),
    .sync_o(pins_s)
  );

  sdl_rx_ctrl #(.FRAME_W(FRAME_W), .ACCEPT_BITS(ACCEPT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .wr_n_s(pins_s[2]), .data_s(pins_s[0]),
    .ready_n(ready_n), .commit(commit), .frame(frame)
  );

  sdl_digit_store #(.NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .frame(frame),
    .disp_seg(disp_seg), .disp_ann(disp_ann)
  );

  a_r1_reset_ready: assert property (@(posedge clk)
    !rst_n |=> ready_n);
endmodule

// File: tb/serial_digit_loader_test.sv
module serial_digit_loader_test;
  localparam int ND = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, wr_n = 1'b1;
  logic ready_n;
  logic [ND*7-1:0] disp_seg;
  logic [ND*2-1:0] disp_ann;

  int n_checks = 0;
  int n_fail = 0;

  logic [6:0] e_seg [ND];
  logic [1:0] e_ann [ND];   // {an2, an1}

  always #2 clk = ~clk;

  serial_digit_loader uut (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .wr_n(wr_n),
    .ready_n(ready_n), .disp_seg(disp_seg), .disp_ann(disp_ann)
  );

  function automatic logic [6:0] font(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  4'd10: return 7'h40; 4'd11: return 7'h79;
      4'd12: return 7'h76; 4'd13: return 7'h38; 4'd14: return 7'h73;
      default: return 7'h00;
    endcase
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_disp(input string req);
    logic [ND*7-1:0] es;
    logic [ND*2-1:0] ea;
    for (int d = 0; d < ND; d++) begin
      es[d*7 +: 7] = e_seg[d];
      ea[d*2 +: 2] = e_ann[d];
    end
    check({req, " seg"}, 128'(disp_seg), 128'(es));
    check({req, " ann"}, 128'(disp_ann), 128'(ea));
  endtask

  task automatic send_bit(input logic b);
    sdata = b;  wait_n(4);
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic strobe();
    wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(6);
  endtask

  // Sends the last n bits of the line order AN1,AN2,BD0..BD3,A0..A3.
  task automatic send_frame(input int n, input logic an1, input logic an2,
                            input logic [3:0] code, input logic [3:0] addr);
    logic [9:0] f;
    f[0] = an1; f[1] = an2;
    for (int i = 0; i < 4; i++) begin
      f[2+i] = code[i];
      f[6+i] = addr[i];
    end
    for (int i = 10 - n; i < 10; i++) send_bit(f[i]);
  endtask

  task automatic model_store(input int n, input logic an1, input logic an2,
                             input logic [3:0] code, input logic [3:0] addr);
    if (int'(addr) < ND) begin
      e_seg[addr] = font(code);
      e_ann[addr] = {(n >= 9) ? an2 : 1'b0, (n >= 10) ? an1 : 1'b0};
    end
  endtask

  task automatic t_reset();
    check("R1 ready_n", 128'(ready_n), 128'(1'b1));
    check_disp("R1");
  endtask

  task automatic t_full_write();
    send_frame(7, 1'b1, 1'b1, 4'd5, 4'd3);
    check("R3 ready_n at 7 bits", 128'(ready_n), 128'(1'b1));
    // 10-bit frame: remaining 3 bits are the tail, so rebuild from scratch
    strobe();
    check("R6 strobe before 8 bits keeps display", 128'(ready_n), 128'(1'b1));
    check_disp("R6");
    send_frame(10, 1'b1, 1'b1, 4'd5, 4'd3);
    check("R3 ready_n at 10 bits", 128'(ready_n), 128'(1'b0));
    strobe();
    model_store(10, 1'b1, 1'b1, 4'd5, 4'd3);
    check("R5 ready_n after commit", 128'(ready_n), 128'(1'b1));
    check_disp("R5 R2 R7 ten-bit write");
  endtask

  task automatic t_short_writes();
    send_frame(8, 1'b1, 1'b1, 4'd7, 4'd0);
    check("R3 ready_n at 8 bits", 128'(ready_n), 128'(1'b0));
    strobe();
    model_store(8, 1'b1, 1'b1, 4'd7, 4'd0);
    check_disp("R7 eight-bit write flags off");
    send_frame(9, 1'b0, 1'b1, 4'd9, 4'd9);
    check("R3 ready_n at 9 bits", 128'(ready_n), 128'(1'b0));
    strobe();
    model_store(9, 1'b0, 1'b1, 4'd9, 4'd9);
    check_disp("R7 nine-bit write AN2 only");
    send_frame(10, 1'b1, 1'b0, 4'd2, 4'd6);
    strobe();
    model_store(10, 1'b1, 1'b0, 4'd2, 4'd6);
    check_disp("R7 R10 ten-bit write AN1 only");
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      send_frame(10, c[0], c[1], 4'(c), 4'(c % ND));
      strobe();
      model_store(10, c[0], c[1], 4'(c), 4'(c % ND));
      check_disp($sformatf("R9 R10 code %0d", c));
    end
  endtask

  task automatic t_bad_addr();
    for (int a = 10; a < 16; a += 5) begin
      send_frame(10, 1'b1, 1'b1, 4'd8, 4'(a));
      check("R8 ready_n before strobe", 128'(ready_n), 128'(1'b0));
      strobe();
      check("R8 ready_n after strobe", 128'(ready_n), 128'(1'b1));
      check_disp($sformatf("R8 address %0d", a));
    end
  endtask

  task automatic t_abort();
    send_frame(10, 1'b1, 1'b1, 4'd4, 4'd1);
    send_bit(1'b1);
    check("R4 ready_n after 11th edge", 128'(ready_n), 128'(1'b1));
    strobe();
    check_disp("R4 aborted frame not stored");
    send_frame(8, 1'b0, 1'b0, 4'd12, 4'd1);
    strobe();
    model_store(8, 1'b0, 1'b0, 4'd12, 4'd1);
    check_disp("R4 R6 fresh frame after abort");
  endtask

  task automatic t_collision();
    send_frame(7, 1'b0, 1'b0, 4'd0, 4'd0);
    wr_n = 1'b0; sdata = 1'b1; wait_n(4);
    sclk = 1'b1; wr_n = 1'b1; wait_n(4);
    sclk = 1'b0; sdata = 1'b0; wait_n(4);
    check("R11 ready_n after collision", 128'(ready_n), 128'(1'b1));
    send_frame(8, 1'b0, 1'b0, 4'd1, 4'd2);
    check("R11 ready_n at 8 fresh bits", 128'(ready_n), 128'(1'b0));
    strobe();
    model_store(8, 1'b0, 1'b0, 4'd1, 4'd2);
    check_disp("R11 clock edge ignored");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int d = 0; d < ND; d++) begin
      e_seg[d] = '0;
      e_ann[d] = '0;
    end
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(3);
    t_full_write();
    t_short_writes();
    t_all_codes();
    t_bad_addr();
    t_abort();
    t_collision();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule